// File: doc/BRIEF.md
# Latched Accessory Output Driver

This block drives sixteen digital enable lines for track switches and layout accessories. It is a peripheral on a host's memory-mapped bus. The host writes two 8-bit latch bytes, one for each half of the lines. It can also write a command byte that sets, clears or pulses a single line, or clears every line at once. The high-current drivers sit outside the block, which supplies only the enables.

Each line is its own small state machine with three states. `LN_LOW` is the idle state with the output low. `LN_HELD` holds a steady high level, which suits motor-driven switch machines. `LN_PULSE` holds the line high for a fixed number of clock cycles and then returns it to low, which suits solenoid switch machines. The default length is 5 ms at a 200 MHz clock. The transitions are:
- `LOW→HELD`: on a set request.
- `LOW→PULSE` and `HELD→PULSE`: on a pulse request, which loads the timer.
- `PULSE→PULSE`: on a pulse request, which reloads the timer.
- `PULSE→LOW`: on timer expiry.
- `HELD→LOW` and `PULSE→LOW`: on a clear request.
- `PULSE→HELD`: on a set request.

A latch write turns each 1 bit into a set request and each 0 bit into a clear request. Reset-all is a clear request to every line.

Top module: `acc_out_driver`

## Requirements
- R1: While `rst_n` is low, and after it rises with no writes since, all sixteen outputs are low.
- R2: A write to `BASE_ADDR` makes `out_lines[7:0]` equal the written byte from the next cycle on. A 1 bit holds the line high. A 0 bit drives it low and cancels any pulse running on that line.
- R3: A write to `BASE_ADDR+1` does the same for `out_lines[15:8]`.
- R4: A write to `BASE_ADDR+2` whose bits 7:6 are `00` sets the line selected by bits 3:0 high from the next cycle. The line stays high until changed, and the other lines are unchanged.
- R5: A command with bits 7:6 = `01` drives the selected line low from the next cycle, and the other lines are unchanged.
- R6: A command with bits 7:6 = `10` drives the selected line high for exactly `PULSE_CYCLES` cycles, starting the cycle after the write, and then low. This holds even if the line was held high before.
- R7: A pulse command on a line that is already pulsing restarts its timer, so the line stays high for `PULSE_CYCLES` cycles after the newer command.
- R8: A command with bits 7:6 = `11` drives all outputs low in the next cycle and cancels every pulse, so no line rises again when its old timer would have expired.
- R9: With `bus_rd` high, `bus_rdata` shows `out_lines[7:0]` at `BASE_ADDR` and `out_lines[15:8]` at `BASE_ADDR+1`, including lines that are pulsing. At any other address it shows zero.
- R10: Writes to addresses outside `BASE_ADDR..BASE_ADDR+2` leave the outputs unchanged. Command bits 5:4 have no effect.
- R11: A set command on a pulsing line turns the pulse into a steady high that stays high after the pulse time has passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read enable |
| bus_addr | input | 8 | Bus address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| out_lines | output | 16 | Enable lines to the drivers |

## Verification
The hardest condition to reach from the ports is a line caught part-way through its timed pulse while another request arrives. That request can be a second pulse, a set, a reset-all or a latch write of zero. To get there, the bench issues a pulse command and counts clock cycles from the write. It then injects the second request at a known offset inside the window. From that point it checks, every cycle, whether the line stays high or falls, against a count it derives from `PULSE_CYCLES`. A short `PULSE_CYCLES` keeps each window small while still testing the expiry boundary exactly.

// File: rtl/acc_out_pkg.sv
package acc_out_pkg;
    localparam int unsigned LATCH_W   = 8;
    localparam int unsigned NUM_LATCH = 2;
    localparam int unsigned NUM_LINES = LATCH_W * NUM_LATCH;
    localparam int unsigned IDX_W     = $clog2(NUM_LINES);

    typedef enum logic [1:0] {
        LN_LOW   = 2'b00,
        LN_HELD  = 2'b01,
        LN_PULSE = 2'b10
    } line_state_t;

    typedef enum logic [1:0] {
        OP_SET       = 2'b00,
        OP_CLR       = 2'b01,
        OP_PULSE     = 2'b10,
        OP_RESET_ALL = 2'b11
    } cmd_op_t;
endpackage

// File: rtl/acc_bus_decode.sv
module acc_bus_decode
    import acc_out_pkg::*;
#(
    parameter logic [7:0] BASE_ADDR = 8'h08
) (
    input  logic                 bus_wr,
    input  logic [7:0]           bus_addr,
    input  logic [7:0]           bus_wdata,
    output logic [NUM_LINES-1:0] set_req,
    output logic [NUM_LINES-1:0] clr_req,
    output logic [NUM_LINES-1:0] pls_req
);
    localparam logic [7:0] LATCH_B_ADDR = BASE_ADDR + 8'd1;
    localparam logic [7:0] CMD_ADDR     = BASE_ADDR + 8'd2;

    cmd_op_t          op;
    logic [IDX_W-1:0] idx;

    assign op  = cmd_op_t'(bus_wdata[7:6]);
    assign idx = bus_wdata[IDX_W-1:0];

    always_comb begin
        set_req = '0;
        clr_req = '0;
        pls_req = '0;
        if (bus_wr) begin
            if (bus_addr == BASE_ADDR) begin
                set_req[LATCH_W-1:0] = bus_wdata;
                clr_req[LATCH_W-1:0] = ~bus_wdata;
            end else if (bus_addr == LATCH_B_ADDR) begin
                set_req[NUM_LINES-1:LATCH_W] = bus_wdata;
                clr_req[NUM_LINES-1:LATCH_W] = ~bus_wdata;
            end else if (bus_addr == CMD_ADDR) begin
                unique case (op)
                    OP_SET:       set_req[idx] = 1'b1;
                    OP_CLR:       clr_req[idx] = 1'b1;
                    OP_PULSE:     pls_req[idx] = 1'b1;
                    OP_RESET_ALL: clr_req      = '1;
                endcase
            end
        end
    end
endmodule

// File: rtl/acc_line_fsm.sv
module acc_line_fsm
    import acc_out_pkg::*;
#(
    parameter int unsigned PULSE_CYCLES = 1_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    input  logic pls_req,
    output logic line_out
);
    localparam int unsigned CNT_W = (PULSE_CYCLES > 1) ? $clog2(PULSE_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PULSE_CYCLES - 1);

    line_state_t      state, state_n;
    logic [CNT_W-1:0] cnt, cnt_n;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= LN_LOW;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

    // Next-state logic; clear outranks set outranks pulse
    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        unique case (state)
            LN_LOW: begin
                if (set_req) begin
                    state_n = LN_HELD;
                end else if (pls_req) begin
                    state_n = LN_PULSE;
                    cnt_n   = '0;
                end
            end
            LN_HELD: begin
                if (clr_req) begin
                    state_n = LN_LOW;
                end else if (pls_req) begin
                    state_n = LN_PULSE;
                    cnt_n   = '0;
                end
            end
            LN_PULSE: begin
                if (clr_req) begin
                    state_n = LN_LOW;
                end else if (set_req) begin
                    state_n = LN_HELD;
                end else if (pls_req) begin
                    cnt_n = '0;
                end else if (cnt == CNT_LAST) begin
                    state_n = LN_LOW;
                end else begin
                    cnt_n = cnt + 1'b1;
                end
            end
            default: state_n = LN_LOW;
        endcase
    end

    // Output decode
    always_comb begin
        line_out = (state != LN_LOW);
    end
endmodule

// File: rtl/acc_out_driver.sv
module acc_out_driver
    import acc_out_pkg::*;
#(
    parameter logic [7:0]  BASE_ADDR    = 8'h08,
    parameter int unsigned PULSE_CYCLES = 1_000_000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [7:0]           bus_addr,
    input  logic [7:0]           bus_wdata,
    output logic [7:0]           bus_rdata,
    output logic [NUM_LINES-1:0] out_lines
);
    localparam logic [7:0] LATCH_B_ADDR = BASE_ADDR + 8'd1;

    logic [NUM_LINES-1:0] set_req, clr_req, pls_req;

    acc_bus_decode #(.BASE_ADDR(BASE_ADDR)) u_dec (
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .set_req  (set_req),
        .clr_req  (clr_req),
        .pls_req  (pls_req)
    );

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        acc_line_fsm #(.PULSE_CYCLES(PULSE_CYCLES)) u_line (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_req (set_req[g]),
            .clr_req (clr_req[g]),
            .pls_req (pls_req[g]),
            .line_out(out_lines[g])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (bus_addr == BASE_ADDR)         bus_rdata = out_lines[LATCH_W-1:0];
            else if (bus_addr == LATCH_B_ADDR) bus_rdata = out_lines[NUM_LINES-1:LATCH_W];
        end
    end
endmodule

// File: rtl/acc_out_driver_chk.sv
module acc_out_driver_chk #(
    parameter logic [7:0] BASE_ADDR = 8'h08
) (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_wr,
    input logic        bus_rd,
    input logic [7:0]  bus_addr,
    input logic [7:0]  bus_wdata,
    input logic [7:0]  bus_rdata,
    input logic [15:0] out_lines
);
    localparam logic [7:0] B_ADDR = BASE_ADDR + 8'd1;
    localparam logic [7:0] C_ADDR = BASE_ADDR + 8'd2;

    logic cmd_wr;
    assign cmd_wr = bus_wr && (bus_addr == C_ADDR);

    a_r1_reset_low: assert property (@(posedge clk)
        !rst_n |=> (out_lines == 16'h0000));

    a_r2_latch_a: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == BASE_ADDR) |=> (out_lines[7:0] == $past(bus_wdata)));

    a_r3_latch_b: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == B_ADDR) |=> (out_lines[15:8] == $past(bus_wdata)));

    a_r4_set_one: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && bus_wdata[7:6] == 2'b00) |=> out_lines[$past(bus_wdata[3:0])]);

    a_r5_clear_one: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && bus_wdata[7:6] == 2'b01) |=> !out_lines[$past(bus_wdata[3:0])]);

    a_r6_pulse_start: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && bus_wdata[7:6] == 2'b10) |=> out_lines[$past(bus_wdata[3:0])]);

    a_r8_reset_all: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && bus_wdata[7:6] == 2'b11) |=> (out_lines == 16'h0000));

    a_r9_read_a: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == BASE_ADDR) |-> (bus_rdata == out_lines[7:0]));
endmodule

bind acc_out_driver acc_out_driver_chk #(.BASE_ADDR(BASE_ADDR)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .out_lines(out_lines)
);

// File: tb/acc_out_driver_bench.sv
`timescale 1ns/1ps
module acc_out_driver_bench;
    localparam logic [7:0] BASE = 8'h20;
    localparam int         PC   = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [15:0] out_lines;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    acc_out_driver #(.BASE_ADDR(BASE), .PULSE_CYCLES(PC)) u_acc_out_driver (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .out_lines(out_lines)
    );

    // {addr, data, expected outputs after the write}
    localparam int NV = 12;
    localparam logic [31:0] VEC [NV] = '{
        {8'h20, 8'hA5, 16'h00A5},   // R2 latch A
        {8'h21, 8'h3C, 16'h3CA5},   // R3 latch B
        {8'h22, 8'h0F, 16'hBCA5},   // R4 set line 15
        {8'h22, 8'h40, 16'hBCA4},   // R5 clear line 0
        {8'h22, 8'h4D, 16'h9CA4},   // R5 clear line 13
        {8'h22, 8'h31, 16'h9CA6},   // R10 bits 5:4 ignored, R4 set line 1
        {8'h23, 8'hFF, 16'h9CA6},   // R10 above window
        {8'h1F, 8'hFF, 16'h9CA6},   // R10 below window
        {8'h22, 8'hC0, 16'h0000},   // R8 reset all
        {8'h21, 8'hFF, 16'hFF00},   // R3
        {8'h20, 8'h0F, 16'hFF0F},   // R2
        {8'h22, 8'h45, 16'hFF0F}    // R5 clear of a low line
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #0.5;
        d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        logic [7:0] r;
        repeat (3) @(negedge clk);
        chk("R1 in reset", out_lines, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", out_lines, 16'h0000);

        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][31:24], VEC[i][23:16]);
            chk($sformatf("R2/R3/R4/R5/R8/R10 vector %0d", i), out_lines, VEC[i][15:0]);
        end

        // R9 readback
        rd(BASE, r);       chk("R9 read A", {8'h00, r}, 16'h000F);
        rd(BASE + 8'd1, r); chk("R9 read B", {8'h00, r}, 16'h00FF);
        rd(BASE + 8'd2, r); chk("R9 read cmd addr", {8'h00, r}, 16'h0000);

        // R6 pulse timing on line 4, which is low
        wr(BASE + 8'd2, 8'h84);
        for (int i = 0; i < PC; i++) begin
            chk("R6 pulse high", {15'h0, out_lines[4]}, 16'h1);
            if (i == 2) begin
                rd(BASE, r);
                chk("R9 read shows pulse", {8'h00, r}, 16'h001F);
            end
            @(negedge clk);
        end
        chk("R6 pulse ends", {15'h0, out_lines[4]}, 16'h0);

        // R6 pulse on a held line (line 0) returns low
        wr(BASE + 8'd2, 8'h80);
        repeat (PC) @(negedge clk);
        chk("R6 held line low after pulse", {15'h0, out_lines[0]}, 16'h0);

        // R7 restart
        wr(BASE + 8'd2, 8'h86);
        repeat (3) @(negedge clk);
        wr(BASE + 8'd2, 8'h86);
        for (int i = 0; i < PC; i++) begin
            chk("R7 restarted pulse high", {15'h0, out_lines[6]}, 16'h1);
            @(negedge clk);
        end
        chk("R7 restarted pulse ends", {15'h0, out_lines[6]}, 16'h0);

        // R11 set during pulse
        wr(BASE + 8'd2, 8'h87);
        wr(BASE + 8'd2, 8'h07);
        repeat (PC + 2) @(negedge clk);
        chk("R11 set holds after pulse time", {15'h0, out_lines[7]}, 16'h1);

        // R2 latch zero cancels pulse on line 5
        wr(BASE + 8'd2, 8'h85);
        wr(BASE, 8'h00);
        chk("R2 latch zero cancels pulse", {8'h00, out_lines[7:0]}, 16'h0000);
        repeat (PC) @(negedge clk);
        chk("R2 cancelled pulse stays low", {8'h00, out_lines[7:0]}, 16'h0000);

        // R8 reset-all cancels pulses
        wr(BASE + 8'd2, 8'h8A);
        wr(BASE + 8'd2, 8'h83);
        wr(BASE + 8'd2, 8'hC0);
        chk("R8 reset all", out_lines, 16'h0000);
        repeat (PC + 2) @(negedge clk);
        chk("R8 no pulse resumes", out_lines, 16'h0000);

        // R10 out-of-window pulse command ignored
        wr(BASE + 8'd3, 8'h82);
        chk("R10 stray pulse ignored", out_lines, 16'h0000);

        // R1 mid-run reset
        wr(BASE + 8'd1, 8'h5A);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset clears outputs", out_lines, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 low after reset release", out_lines, 16'h0000);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule